// File: doc/BRIEF.md
# Double-Buffered Sprite Line Buffer

This block keeps two pixel rows of sprite colour for a raster display. While one row (the fill side) is built up for the coming scanline, the other row (the display side) is read out pixel by pixel for the scanline being drawn. A sprite fetch engine offers one 16-pixel sprite row per load. The row arrives as four 16-bit bitplanes, plus a 4-bit colour attribute and a 9-bit horizontal start position. All opaque pixels of that row are written into the fill side in a single clock cycle.

Two line strobes drive the block. A clear strobe near the start of a line erases the fill side and reopens it for loads. A swap strobe near the end of the line exchanges the two sides. The display side is addressed by an 8-bit column. It returns a colour byte, made of the attribute above the 4-bit pixel value, and a transparent flag. A small state machine counts the loads accepted since the last clear. It raises a full flag once the per-line limit is reached, which tells the sprite scanner to stop offering candidates for that line.

The state machine has two states. ST_OPEN accepts loads. ST_FULL drops them. ST_OPEN moves to ST_FULL on the accepted load that reaches the limit. ST_FULL returns to ST_OPEN on a clear strobe. A clear strobe in ST_OPEN stays in ST_OPEN and zeroes the count.

Top module: `sprite_line_buf`

## Requirements
- R1: After reset, full is 0, rd_transp is 1 and rd_color is 0 for every column of both sides.
- R2: Pixel i of a load (i = 0..15) has the 4-bit value {ld_planes[48+i], ld_planes[32+i], ld_planes[16+i], ld_planes[i]} and is stored at column ld_x+i. Reading it returns rd_color = {ld_attr, value} and rd_transp = 0.
- R3: A pixel whose value is 0 is not written, so the column keeps its previous contents.
- R4: A pixel whose column ld_x+i is 256 or more is dropped. It does not wrap to a low column.
- R5: A later accepted load overwrites earlier contents at every column where it has an opaque pixel.
- R6: On a line_swap edge, the fill side becomes the display side and the display side becomes the fill side. The new fill side keeps its old contents until it is cleared.
- R7: line_clr erases only the current fill side. Every cleared column then reads transparent with colour 0, and the display side is unchanged.
- R8: full rises after the 16th accepted load since the last clear. Loads offered while full is 1 are ignored. A clear returns full to 0.
- R9: A load offered in the same cycle as line_clr or line_swap is dropped and is not counted.
- R10: rd_color and rd_transp show the column that rd_col held at the previous rising edge, one cycle of read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_clr | input | 1 | Erase the fill side and reopen it for loads |
| line_swap | input | 1 | Exchange the fill and display sides |
| ld_valid | input | 1 | A sprite row is offered this cycle |
| ld_planes | input | 64 | Four bitplanes, plane p in bits 16p+15..16p, pixel i at bit i of each plane |
| ld_attr | input | 4 | Colour attribute of the sprite |
| ld_x | input | 9 | Column of pixel 0 |
| rd_col | input | 8 | Display column to read |
| rd_color | output | 8 | Colour byte {attribute, pixel value} |
| rd_transp | output | 1 | Column holds no opaque pixel |
| full | output | 1 | No more loads accepted this line |

## Verification
A load, clear or swap takes effect at the rising edge where it is presented. Its result shows up on the read port one edge later, when the next read of that column is captured. full changes right at the edge that accepts the 16th load or applies the clear. rd_color and rd_transp follow rd_col with one edge of delay. The bench drives every input on the falling edge and samples outputs one nanosecond after the following rising edge, and it updates its reference model at that same edge. One latency check samples just before the edge to show that a new column has not yet reached the output.

// File: rtl/slb_pkg.sv
package slb_pkg;
    typedef enum logic [0:0] {
        ST_OPEN = 1'b0,
        ST_FULL = 1'b1
    } fill_state_t;
endpackage

// File: rtl/slb_row_decode.sv
module slb_row_decode #(
    parameter int PIX    = 16,
    parameter int PLANES = 4
) (
    input  logic [PLANES*PIX-1:0] planes,
    output logic [PIX*PLANES-1:0] pix
);
    // gather bit i of every plane into pixel i
    for (genvar i = 0; i < PIX; i++) begin : g_pix
        for (genvar p = 0; p < PLANES; p++) begin : g_plane
            assign pix[i*PLANES+p] = planes[p*PIX+i];
        end
    end
endmodule

// File: rtl/slb_line_mem.sv
module slb_line_mem #(
    parameter int COLS   = 256,
    parameter int PIX    = 16,
    parameter int PIX_W  = 4,
    parameter int ATTR_W = 4,
    parameter int X_W    = 9,
    localparam int COL_W = $clog2(COLS),
    localparam int EW    = ATTR_W + PIX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic [X_W-1:0]       wr_x,
    input  logic [PIX*PIX_W-1:0] wr_pix,
    input  logic [ATTR_W-1:0]    wr_attr,
    input  logic [COL_W-1:0]     rd_col,
    output logic                 rd_valid,
    output logic [EW-1:0]        rd_data
);
    localparam logic [X_W:0] LIMIT = (X_W+1)'(COLS);

    logic [EW-1:0]   ent [COLS];
    logic [COLS-1:0] vld;
    logic [X_W:0]    pos [PIX];
    logic [PIX-1:0]  hit;

    for (genvar i = 0; i < PIX; i++) begin : g_lane
        assign pos[i] = {1'b0, wr_x} + (X_W+1)'(i);
        assign hit[i] = wr_en && (wr_pix[i*PIX_W +: PIX_W] != '0) && (pos[i] < LIMIT);
    end

    // occupancy bits: cleared in one cycle, set by opaque writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (clr) begin
            vld <= '0;
        end else begin
            for (int i = 0; i < PIX; i++) begin
                if (hit[i]) vld[pos[i][COL_W-1:0]] <= 1'b1;
            end
        end
    end

    // colour storage, qualified by occupancy on read
    always_ff @(posedge clk) begin
        for (int i = 0; i < PIX; i++) begin
            if (hit[i]) ent[pos[i][COL_W-1:0]] <= {wr_attr, wr_pix[i*PIX_W +: PIX_W]};
        end
    end

    assign rd_valid = vld[rd_col];
    assign rd_data  = ent[rd_col];
endmodule

// File: rtl/slb_ctrl.sv
module slb_ctrl
    import slb_pkg::*;
#(
    parameter int MAX_LOADS = 16,
    localparam int CW = $clog2(MAX_LOADS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_clr,
    input  logic line_swap,
    input  logic ld_valid,
    output logic accept,
    output logic full,
    output logic fill_sel
);
    fill_state_t    state, state_nxt;
    logic [CW-1:0]  cnt, cnt_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_OPEN;
            cnt      <= '0;
            fill_sel <= 1'b0;
        end else begin
            state    <= state_nxt;
            cnt      <= cnt_nxt;
            fill_sel <= fill_sel ^ line_swap;
        end
    end

    // next state and outputs
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        accept    = 1'b0;
        full      = (state == ST_FULL);
        unique case (state)
            ST_OPEN: begin
                if (line_clr) begin
                    cnt_nxt = '0;
                end else if (ld_valid && !line_swap) begin
                    accept  = 1'b1;
                    cnt_nxt = cnt + 1'b1;
                    if (cnt == CW'(MAX_LOADS - 1)) state_nxt = ST_FULL;
                end
            end
            ST_FULL: begin
                if (line_clr) begin
                    state_nxt = ST_OPEN;
                    cnt_nxt   = '0;
                end
            end
            default: state_nxt = ST_OPEN;
        endcase
    end
endmodule

// File: rtl/sprite_line_buf.sv
module sprite_line_buf #(
    parameter int COLS      = 256,
    parameter int PIX       = 16,
    parameter int PLANES    = 4,
    parameter int ATTR_W    = 4,
    parameter int X_W       = 9,
    parameter int MAX_LOADS = 16,
    localparam int COL_W    = $clog2(COLS),
    localparam int EW       = ATTR_W + PLANES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    line_clr,
    input  logic                    line_swap,
    input  logic                    ld_valid,
    input  logic [PLANES*PIX-1:0]   ld_planes,
    input  logic [ATTR_W-1:0]       ld_attr,
    input  logic [X_W-1:0]          ld_x,
    input  logic [COL_W-1:0]        rd_col,
    output logic [EW-1:0]           rd_color,
    output logic                    rd_transp,
    output logic                    full
);
    logic                 accept;
    logic                 fill_sel;
    logic                 disp_sel;
    logic [PIX*PLANES-1:0] pix;
    logic                 side_valid [2];
    logic [EW-1:0]        side_data  [2];

    slb_ctrl #(.MAX_LOADS(MAX_LOADS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_clr  (line_clr),
        .line_swap (line_swap),
        .ld_valid  (ld_valid),
        .accept    (accept),
        .full      (full),
        .fill_sel  (fill_sel)
    );

    slb_row_decode #(.PIX(PIX), .PLANES(PLANES)) u_dec (
        .planes (ld_planes),
        .pix    (pix)
    );

    for (genvar b = 0; b < 2; b++) begin : g_side
        slb_line_mem #(
            .COLS(COLS), .PIX(PIX), .PIX_W(PLANES), .ATTR_W(ATTR_W), .X_W(X_W)
        ) u_mem (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (line_clr && (fill_sel == 1'(b))),
            .wr_en    (accept && (fill_sel == 1'(b))),
            .wr_x     (ld_x),
            .wr_pix   (pix),
            .wr_attr  (ld_attr),
            .rd_col   (rd_col),
            .rd_valid (side_valid[b]),
            .rd_data  (side_data[b])
        );
    end

    assign disp_sel = ~fill_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_color  <= '0;
            rd_transp <= 1'b1;
        end else begin
            rd_color  <= side_valid[disp_sel] ? side_data[disp_sel] : '0;
            rd_transp <= !side_valid[disp_sel];
        end
    end
endmodule

// File: rtl/slb_check.sv
module slb_check #(
    parameter int MAX_LOADS = 16,
    parameter int PIX_W     = 4,
    parameter int EW        = 8,
    localparam int CW       = $clog2(MAX_LOADS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          line_clr,
    input logic          line_swap,
    input logic          ld_valid,
    input logic          full,
    input logic [EW-1:0] rd_color,
    input logic          rd_transp
);
    // independent tally of loads the port rules allow since the last clear
    logic [CW-1:0] tally;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tally <= '0;
        else if (line_clr) tally <= '0;
        else if (ld_valid && !line_swap && (tally < CW'(MAX_LOADS))) tally <= tally + 1'b1;
    end

    p_transp_blank_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_transp |-> (rd_color == '0));

    p_opaque_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_transp |-> (rd_color[PIX_W-1:0] != '0));

    p_full_at_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tally == CW'(MAX_LOADS)) |-> full);

    p_full_exact_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (tally == CW'(MAX_LOADS)));

    p_clr_reopen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        line_clr |=> !full);
endmodule

bind sprite_line_buf slb_check #(.MAX_LOADS(MAX_LOADS), .PIX_W(PLANES), .EW(EW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_clr  (line_clr),
    .line_swap (line_swap),
    .ld_valid  (ld_valid),
    .full      (full),
    .rd_color  (rd_color),
    .rd_transp (rd_transp)
);

// File: tb/sim_sprite_line_buf.sv
`timescale 1ns/1ps
module sim_sprite_line_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_clr = 1'b0, line_swap = 1'b0, ld_valid = 1'b0;
    logic [63:0] ld_planes = '0;
    logic [3:0]  ld_attr = '0;
    logic [8:0]  ld_x = '0;
    logic [7:0]  rd_col = '0;
    logic [7:0]  rd_color;
    logic        rd_transp, full;

    always #10 clk = ~clk;

    sprite_line_buf u0 (
        .clk(clk), .rst_n(rst_n), .line_clr(line_clr), .line_swap(line_swap),
        .ld_valid(ld_valid), .ld_planes(ld_planes), .ld_attr(ld_attr), .ld_x(ld_x),
        .rd_col(rd_col), .rd_color(rd_color), .rd_transp(rd_transp), .full(full)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [7:0] mdl [2][256];
    int mfill = 0, mcnt = 0;

    function automatic logic [63:0] to_planes(input logic [63:0] pv);
        logic [63:0] r = '0;
        for (int i = 0; i < 16; i++)
            for (int p = 0; p < 4; p++)
                r[p*16+i] = pv[i*4+p];
        return r;
    endfunction

    task automatic step(input bit c, input bit s, input bit v,
                        input logic [63:0] pv, input logic [3:0] a, input logic [8:0] x);
        @(negedge clk);
        line_clr = c; line_swap = s; ld_valid = v;
        ld_planes = to_planes(pv); ld_attr = a; ld_x = x;
        @(posedge clk);
        #1;
        if (v && !c && !s && mcnt < 16) begin
            for (int i = 0; i < 16; i++) begin
                int pos = int'(x) + i;
                if (pv[i*4 +: 4] != 4'd0 && pos < 256) mdl[mfill][pos] = {a, pv[i*4 +: 4]};
            end
            mcnt++;
        end
        if (c) begin
            for (int k = 0; k < 256; k++) mdl[mfill][k] = 8'd0;
            mcnt = 0;
        end
        if (s) mfill ^= 1;
        line_clr = 0; line_swap = 0; ld_valid = 0;
    endtask

    task automatic do_load(input logic [63:0] pv, input logic [3:0] a, input logic [8:0] x);
        step(0, 0, 1, pv, a, x);
    endtask
    task automatic do_clr();  step(1, 0, 0, '0, '0, '0); endtask
    task automatic do_swap(); step(0, 1, 0, '0, '0, '0); endtask

    task automatic check_col(input int col, input string tag);
        logic [7:0] e;
        @(negedge clk);
        rd_col = 8'(col);
        @(posedge clk);
        #1;
        e = mdl[mfill ^ 1][col];
        checks++;
        if (rd_color !== e || rd_transp !== (e == 8'd0)) begin
            fails++;
            $display("FAIL %s col=%0d actual color=%h transp=%b expected color=%h transp=%b",
                     tag, col, rd_color, rd_transp, e, (e == 8'd0));
        end
    endtask

    task automatic check_full(input string tag);
        checks++;
        if (full !== (mcnt >= 16)) begin
            fails++;
            $display("FAIL %s full actual=%b expected=%b", tag, full, (mcnt >= 16));
        end
    endtask

    function automatic logic [63:0] fill_pv(input logic [3:0] v);
        logic [63:0] r;
        for (int i = 0; i < 16; i++) r[i*4 +: 4] = v;
        return r;
    endfunction

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] pv;
        void'($urandom(32'd4242));
        for (int b = 0; b < 2; b++) for (int k = 0; k < 256; k++) mdl[b][k] = 8'd0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state on both sides
        check_full("R1");
        check_col(0, "R1"); check_col(128, "R1"); check_col(255, "R1");
        do_swap();
        check_col(0, "R1"); check_col(255, "R1");

        // R2 plane assembly and colour byte
        do_clr();
        pv = '0; pv[3:0] = 4'h5; pv[7:4] = 4'hC; pv[63:60] = 4'h9; pv[35:32] = 4'h2;
        do_load(pv, 4'hA, 9'd10);
        do_swap();
        for (int c = 9; c < 28; c++) check_col(c, "R2");

        // R3 zero pixels keep contents, R5 overwrite
        do_clr();
        do_load(fill_pv(4'hF), 4'h1, 9'd40);
        pv = '0;
        for (int i = 1; i < 16; i += 2) pv[i*4 +: 4] = 4'h3;
        do_load(pv, 4'h2, 9'd40);
        do_swap();
        for (int c = 38; c < 58; c++) check_col(c, (c % 2 == 0) ? "R3" : "R5");

        // R4 right edge drop, no wrap
        do_clr();
        do_load(fill_pv(4'h7), 4'h3, 9'd250);
        do_load(fill_pv(4'h6), 4'h4, 9'd300);
        do_swap();
        for (int c = 0; c < 12; c++) check_col(c, "R4");
        for (int c = 246; c < 256; c++) check_col(c, "R4");

        // R7 clear hits fill only; R6 new fill keeps old contents
        do_clr();
        for (int c = 248; c < 256; c++) check_col(c, "R7");
        do_swap();
        for (int c = 248; c < 256; c++) check_col(c, "R7");
        do_swap();
        for (int c = 248; c < 256; c++) check_col(c, "R6");

        // R10 one cycle read latency
        @(negedge clk); rd_col = 8'd0;
        @(posedge clk); #1;
        @(negedge clk); rd_col = 8'd252; #5;
        checks++;
        if (rd_color !== mdl[mfill ^ 1][0]) begin
            fails++;
            $display("FAIL R10 early actual=%h expected=%h", rd_color, mdl[mfill ^ 1][0]);
        end
        check_col(252, "R10");

        // R9 load with clear or swap dropped and not counted
        do_clr();
        step(1, 0, 1, fill_pv(4'h8), 4'h5, 9'd0);
        step(0, 1, 1, fill_pv(4'h8), 4'h5, 9'd0);
        for (int c = 0; c < 4; c++) check_col(c, "R9");
        do_swap();
        for (int c = 0; c < 4; c++) check_col(c, "R9");

        // R8 limit, ignore when full, reopen on clear
        do_clr();
        for (int n = 0; n < 15; n++) do_load(fill_pv(4'h1), 4'(n), 9'(n * 8));
        check_full("R9");
        do_load(fill_pv(4'h2), 4'h7, 9'd160);
        check_full("R8");
        do_load(fill_pv(4'hE), 4'hF, 9'd200);
        check_full("R8");
        do_swap();
        for (int c = 196; c < 218; c++) check_col(c, "R8");
        do_clr();
        check_full("R8");

        // random lines
        for (int ln = 0; ln < 20; ln++) begin
            int n = $urandom_range(0, 20);
            do_clr();
            for (int k = 0; k < n; k++) begin
                pv = '0;
                for (int i = 0; i < 16; i++)
                    if ($urandom_range(0, 2) != 0) pv[i*4 +: 4] = 4'($urandom_range(1, 15));
                do_load(pv, 4'($urandom), 9'($urandom_range(0, 300)));
            end
            check_full("R8");
            do_swap();
            for (int c = 0; c < 256; c++) check_col(c, "R2 R5");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule